// File: doc/BRIEF.md
# Multichannel Per-Channel Audio Sample Delay

This block holds back up to eight audio channels, each by its own whole number of sample periods, so that sound can be aligned with a picture path that has a longer latency. The channels arrive as four two-channel lanes on a single wide input word. The outputs leave on a matching wide output word. A sample-rate strobe marks each new frame of input samples.

All channels share one behavioural synchronous sample RAM of `2**MEM_AW` words. The RAM is split into equal circular regions, one for each active channel. Two-, four- and eight-channel modes are available. Fewer channels give each channel a longer region and therefore a longer possible delay.

Once per strobe a sequencer visits every active channel in turn. For each channel it writes the new sample at the shared write pointer, then reads back the sample from `delay` frames earlier. A small register file holds the eight delay values and the mode. The full output frame is presented in one go, with a one-cycle valid pulse.

Top module: `mc_audio_delay`

## Requirements
- R1: After reset, `dout` is zero, `dout_valid` is low, the mode is two-channel and every delay is zero. Each input frame therefore reappears unchanged on channels 0 and 1.
- R2: A write with `cfg_we` high stores `cfg_wdata` as follows. Addresses 0 to 7 set the delay of channels 0 to 7. Address 8 sets the mode from `cfg_wdata[1:0]`: 0 selects two channels, 1 selects four, and 2 or 3 select eight. Writes to addresses 9 to 15 change nothing.
- R3: Channel k occupies bits `[k*SAMPLE_W +: SAMPLE_W]` of `din` and of `dout`. Lane L carries channels 2L and 2L+1. The output of an active channel equals its input from exactly d strobes earlier, where d is that channel's own delay.
- R4: A delay of zero presents the sample taken at a strobe in the output frame produced for that same strobe.
- R5: Each active channel owns a region of R = `2**MEM_AW` / N words, where N is the active channel count. A programmed delay of R or more acts as R-1.
- R6: In every output frame, channels numbered N and above are zero.
- R7: A new mode takes effect at the next strobe and restarts the write pointer. The output of a channel is zero whenever its effective delay exceeds the number of frames accepted since the last mode change or reset.
- R8: `dout_valid` is a single-cycle pulse. It is high 3N+1 clock edges after the edge that samples `sample_stb`. `dout` changes only together with this pulse.
- R9: A strobe that arrives while a frame is still being processed is ignored. It produces no extra output frame and leaves later frames unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle pulse per sample period; `din` is captured on it |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address (0-7 delays, 8 mode) |
| cfg_wdata | input | DLY_W | Configuration write data |
| din | input | 8*SAMPLE_W | Input samples, channel k at bits k*SAMPLE_W |
| dout | output | 8*SAMPLE_W | Delayed output samples, same layout as `din` |
| dout_valid | output | 1 | Pulse marking a new output frame |

## Verification
Two kinds of internal fault can occur. A wrong write pointer or region base makes a channel return a sample from the wrong frame or from another channel's region. A wrong clamp or mute decision makes a channel return stale or non-zero data. Either fault shows up in the first output frame that reads the affected location. In the worst case that is d+1 strobes after the fault, because a read only looks back d frames. The scoreboard therefore runs long enough to cover the largest delay in each mode. A sequencer that miscounts channels shows up at once as a shifted `dout_valid` pulse, since the pulse must arrive at a fixed latency after each strobe.

// File: rtl/mcad_pkg.sv
package mcad_pkg;

    localparam int NUM_CH    = 8;
    localparam int NUM_LANES = NUM_CH / 2;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int CFG_AW    = 4;
    localparam logic [CFG_AW-1:0] CFG_MODE_ADDR = 4'd8;

    typedef enum logic [1:0] {
        CM_TWO   = 2'd0,
        CM_FOUR  = 2'd1,
        CM_EIGHT = 2'd2
    } chan_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR,
        SQ_RD,
        SQ_CAP,
        SQ_DONE
    } seq_state_e;

    // one memory access request from the sequencer to the address generator
    typedef struct packed {
        logic            rd;
        logic [CH_W-1:0] ch;
    } acc_req_t;

    function automatic chan_mode_e decode_mode(input logic [1:0] v);
        case (v)
            2'd0:    return CM_TWO;
            2'd1:    return CM_FOUR;
            default: return CM_EIGHT;
        endcase
    endfunction

    // log2 of the number of active channels
    function automatic logic [1:0] mode_shift(input chan_mode_e m);
        case (m)
            CM_TWO:  return 2'd1;
            CM_FOUR: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [CH_W:0] active_count(input chan_mode_e m);
        return (CH_W+1)'(1) << mode_shift(m);
    endfunction

endpackage

// File: rtl/mcad_cfg_regs.sv
module mcad_cfg_regs
    import mcad_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [DLY_W-1:0]               cfg_wdata,
    output logic [NUM_CH-1:0][DLY_W-1:0]   delay_q,
    output chan_mode_e                     mode_q
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                delay_q[k] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(k)) begin
                delay_q[k] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CM_TWO;
        end else if (cfg_we && cfg_addr == CFG_MODE_ADDR) begin
            mode_q <= decode_mode(cfg_wdata[1:0]);
        end
    end

endmodule

// File: rtl/mcad_addr_gen.sv
module mcad_addr_gen
    import mcad_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DLY_W = 12
) (
    input  chan_mode_e                     mode,
    input  acc_req_t                       req,
    input  logic [AW-1:0]                  wp,
    input  logic [NUM_CH-1:0][DLY_W-1:0]   delays,
    output logic [AW-1:0]                  addr,
    output logic [AW-1:0]                  deff,
    output logic [AW:0]                    region_len
);

    localparam int CW = ((DLY_W > AW) ? DLY_W : AW) + 1;

    logic [7:0]       rbits;
    logic [AW-1:0]    mask;
    logic [AW-1:0]    base;
    logic [AW-1:0]    offs;
    logic [DLY_W-1:0] dsel;

    always_comb begin
        rbits      = 8'(AW) - 8'(mode_shift(mode));
        region_len = (AW+1)'(1) << rbits;
        mask       = AW'(region_len - 1'b1);
        dsel       = delays[req.ch];
        if (CW'(dsel) >= CW'(region_len)) begin
            deff = mask;
        end else begin
            deff = AW'(dsel);
        end
        base = AW'(req.ch) << rbits;
        if (req.rd) begin
            offs = (wp - deff) & mask;
        end else begin
            offs = wp & mask;
        end
        addr = base | offs;
    end

endmodule

// File: rtl/mcad_sample_ram.sv
module mcad_sample_ram #(
    parameter int AW = 10,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/mcad_frame_seq.sv
module mcad_frame_seq
    import mcad_pkg::*;
#(
    parameter int AW = 10,
    parameter int W  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb,
    input  logic [NUM_CH-1:0][W-1:0]   din_v,
    input  chan_mode_e                 mode_cfg,
    input  logic [AW-1:0]              deff,
    input  logic [AW:0]                region_len,
    input  logic [W-1:0]               ram_rdata,
    output acc_req_t                   req,
    output logic                       ram_we,
    output logic [W-1:0]               ram_wdata,
    output logic [AW-1:0]              wp,
    output chan_mode_e                 act_mode,
    output logic [NUM_CH-1:0][W-1:0]   dout_v,
    output logic                       dout_valid
);

    seq_state_e                 state;
    logic [CH_W-1:0]            ch;
    logic [AW:0]                fill;
    logic                       mute_q;
    logic [NUM_CH-1:0][W-1:0]   in_buf;
    logic [NUM_CH-1:0][W-1:0]   out_buf;
    logic                       last_ch;

    always_comb begin
        req.ch    = ch;
        req.rd    = (state == SQ_RD);
        ram_we    = (state == SQ_WR);
        ram_wdata = in_buf[ch];
        last_ch   = (ch == CH_W'(active_count(act_mode) - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ch         <= '0;
            wp         <= '0;
            fill       <= '0;
            mute_q     <= 1'b0;
            act_mode   <= CM_TWO;
            in_buf     <= '0;
            out_buf    <= '0;
            dout_v     <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (stb) begin
                        in_buf  <= din_v;
                        out_buf <= '0;
                        ch      <= '0;
                        state   <= SQ_WR;
                        if (mode_cfg != act_mode) begin
                            act_mode <= mode_cfg;
                            wp       <= '0;
                            fill     <= '0;
                        end
                    end
                end
                SQ_WR: begin
                    state <= SQ_RD;
                end
                SQ_RD: begin
                    // the slot was last written before the mode change if the lag exceeds the fill
                    mute_q <= ({1'b0, deff} > fill);
                    state  <= SQ_CAP;
                end
                SQ_CAP: begin
                    out_buf[ch] <= mute_q ? '0 : ram_rdata;
                    if (last_ch) begin
                        state <= SQ_DONE;
                    end else begin
                        ch    <= ch + 1'b1;
                        state <= SQ_WR;
                    end
                end
                SQ_DONE: begin
                    dout_v     <= out_buf;
                    dout_valid <= 1'b1;
                    wp         <= (wp + 1'b1) & AW'(region_len - 1'b1);
                    if (fill != region_len) begin
                        fill <= fill + 1'b1;
                    end
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mc_audio_delay.sv
module mc_audio_delay
    import mcad_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int MEM_AW   = 10,
    parameter int DLY_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sample_stb,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [DLY_W-1:0]             cfg_wdata,
    input  logic [NUM_CH*SAMPLE_W-1:0]   din,
    output logic [NUM_CH*SAMPLE_W-1:0]   dout,
    output logic                         dout_valid
);

    logic [NUM_CH-1:0][DLY_W-1:0]    delay_q;
    chan_mode_e                      mode_q;
    chan_mode_e                      act_mode;
    acc_req_t                        req;
    logic [MEM_AW-1:0]               wp;
    logic [MEM_AW-1:0]               ram_addr;
    logic [MEM_AW-1:0]               deff;
    logic [MEM_AW:0]                 region_len;
    logic                            ram_we;
    logic [SAMPLE_W-1:0]             ram_wdata;
    logic [SAMPLE_W-1:0]             ram_rdata;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] din_v;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] dout_v;

    assign din_v = din;
    assign dout  = dout_v;

    mcad_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .delay_q   (delay_q),
        .mode_q    (mode_q)
    );

    mcad_addr_gen #(.AW(MEM_AW), .DLY_W(DLY_W)) u_addr (
        .mode       (act_mode),
        .req        (req),
        .wp         (wp),
        .delays     (delay_q),
        .addr       (ram_addr),
        .deff       (deff),
        .region_len (region_len)
    );

    mcad_frame_seq #(.AW(MEM_AW), .W(SAMPLE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stb        (sample_stb),
        .din_v      (din_v),
        .mode_cfg   (mode_q),
        .deff       (deff),
        .region_len (region_len),
        .ram_rdata  (ram_rdata),
        .req        (req),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .wp         (wp),
        .act_mode   (act_mode),
        .dout_v     (dout_v),
        .dout_valid (dout_valid)
    );

    mcad_sample_ram #(.AW(MEM_AW), .W(SAMPLE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/mcad_chk.sv
module mcad_chk
    import mcad_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   dout_valid,
    input logic [NUM_CH*W-1:0]    dout,
    input chan_mode_e             act_mode,
    input acc_req_t               req,
    input logic                   ram_we,
    input logic [AW-1:0]          ram_addr,
    input logic [AW-1:0]          deff,
    input logic [AW:0]            region_len
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> !dout_valid); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> $stable(dout)); // R8

    AST_DELAY_CLAMP: assert property (@(posedge clk) disable iff (rst)
        req.rd |-> ({1'b0, deff} < region_len)); // R5

    AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        (ram_we || req.rd) |-> (({1'b0, ram_addr} / region_len) == (AW+1)'(req.ch))); // R5

    for (genvar k = 2; k < NUM_CH; k++) begin : g_idle_ch
        AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (dout_valid && (k >= int'(active_count(act_mode)))) |-> (dout[k*W +: W] == '0)); // R6
    end

endmodule

bind mc_audio_delay mcad_chk #(.W(SAMPLE_W), .AW(MEM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dout_valid (dout_valid),
    .dout       (dout),
    .act_mode   (act_mode),
    .req        (req),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .deff       (deff),
    .region_len (region_len)
);

// File: tb/tb_mc_audio_delay.sv
`timescale 1ns/1ps
module tb_mc_audio_delay;
    import mcad_pkg::*;

    localparam int W     = 16;
    localparam int AW    = 10;
    localparam int DLY_W = 12;
    localparam int GAP   = 128;
    localparam int HIST  = 512;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_stb = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [CFG_AW-1:0]    cfg_addr = '0;
    logic [DLY_W-1:0]     cfg_wdata = '0;
    logic [NUM_CH*W-1:0]  din = '0;
    logic [NUM_CH*W-1:0]  dout;
    logic                 dout_valid;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // reference model state
    int cfg_mode = 0;
    int app_mode = 0;
    int dly [NUM_CH];
    int nf = 0;
    logic [W-1:0] hist [NUM_CH][HIST];
    logic [NUM_CH*W-1:0] exp_q [$];
    int                  cyc_q [$];
    string               tag_q [$];

    mc_audio_delay #(.SAMPLE_W(W), .MEM_AW(AW), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din),
        .dout(dout), .dout_valid(dout_valid)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int n_active(input int m);
        return (m == 0) ? 2 : (m == 1) ? 4 : 8;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = CFG_AW'(addr);
        cfg_wdata = DLY_W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < NUM_CH) dly[addr] = data;
        else if (addr == 8) cfg_mode = ((data & 3) == 0) ? 0 : ((data & 3) == 1) ? 1 : 2;
    endtask

    // driver: one input frame, expected output pushed to the scoreboard
    task automatic frame(input string tag, input bit extra_stb);
        logic [NUM_CH*W-1:0] val;
        logic [NUM_CH*W-1:0] ev;
        int na, reg_len, de;
        @(negedge clk);
        if (cfg_mode != app_mode) begin
            app_mode = cfg_mode;
            nf = 0;
        end
        na = n_active(app_mode);
        reg_len = (1 << AW) / na;
        ev = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            val[k*W +: W] = W'($urandom);
            hist[k][nf % HIST] = val[k*W +: W];
        end
        for (int k = 0; k < na; k++) begin
            de = (dly[k] >= reg_len) ? reg_len - 1 : dly[k];
            if (de <= nf) ev[k*W +: W] = hist[k][(nf - de) % HIST];
        end
        nf++;
        exp_q.push_back(ev);
        cyc_q.push_back(cyc + 3 * na + 2);
        tag_q.push_back(tag);
        din = val;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        if (extra_stb) begin
            repeat (4) @(negedge clk);
            sample_stb = 1'b1;
            din = ~val;
            @(negedge clk);
            sample_stb = 1'b0;
        end
        repeat (GAP) @(negedge clk);
    endtask

    // monitor: compare each output frame against the scoreboard
    always @(negedge clk) begin
        if (!rst && dout_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected frame", 64'(dout[63:0]), 64'd0);
            end else begin
                logic [NUM_CH*W-1:0] ev;
                int ec;
                string tg;
                ev = exp_q.pop_front();
                ec = cyc_q.pop_front();
                tg = tag_q.pop_front();
                check(cyc == ec, "R8 latency", 64'(cyc), 64'(ec));
                for (int k = 0; k < NUM_CH; k++) begin
                    check(dout[k*W +: W] == ev[k*W +: W], $sformatf("%s ch%0d", tg, k),
                          64'(dout[k*W +: W]), 64'(ev[k*W +: W]));
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 64'(cyc), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NUM_CH; k++) dly[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dout == '0, "R1 reset dout", 64'(dout[63:0]), 64'd0);
        check(dout_valid == 1'b0, "R1 reset valid", 64'(dout_valid), 64'd0);

        // R1: default mode and zero delays pass samples straight through
        repeat (3) frame("R1", 1'b0);

        // R3 R4: independent delays in two-channel mode
        cfg_write(0, 3);
        cfg_write(1, 0);
        repeat (10) frame("R3 R4", 1'b0);

        // R7 R6: switch to eight channels, stale reads muted
        cfg_write(8, 2);
        cfg_write(0, 0); cfg_write(1, 1); cfg_write(2, 2); cfg_write(3, 5);
        cfg_write(4, 9); cfg_write(5, 17); cfg_write(6, 40); cfg_write(7, 127);
        repeat (50) frame("R3 R6 R7", 1'b0);

        // R5: oversized delays clamp to region length minus one
        cfg_write(6, 128);
        cfg_write(7, 500);
        repeat (100) frame("R5", 1'b0);

        // R2: writes to unused addresses change nothing
        cfg_write(12, 7);
        cfg_write(15, 1);
        repeat (3) frame("R2", 1'b0);

        // R9: strobe during processing is ignored
        repeat (2) frame("R9", 1'b1);

        // R5 R7: four-channel mode, clamp at 255
        cfg_write(8, 1);
        cfg_write(0, 300); cfg_write(1, 0); cfg_write(2, 64); cfg_write(3, 255);
        repeat (270) frame("R5 R6 R7", 1'b0);

        // R2: mode code 3 selects eight channels
        cfg_write(8, 3);
        repeat (5) frame("R2 R7", 1'b0);

        // R3 R5: two-channel mode with the longest delay
        cfg_write(8, 0);
        cfg_write(0, 511);
        cfg_write(1, 400);
        repeat (520) frame("R3 R5", 1'b0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 frames outstanding", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule